// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog counter that sits behind a small four-word register interface. Software must feed it before the count reaches a programmed limit. If it does not, the block raises a one-cycle reset request. A nonzero window value makes a feed that comes too early count as a fault as well. All command words go to the counter register. One pair of consecutive key words opens a short configuration period. A different pair of consecutive key words returns the count to zero.

Configuration is protected in three stages. From reset until the first write to the control word, the configuration registers accept writes directly and the unlock keys do nothing. That first control write decides what happens next. If it sets the update-permission bit, later changes are possible, but only inside an unlock period. That period closes after a fixed number of cycles or when the control word is written again. If it leaves the bit clear, the configuration is frozen until reset. Two status bits let software see whether an unlock period is open and whether a new configuration has been applied.

Top module: `kp_wdog`

## Requirements
- R1: Reset values: control reads 0x0080 (enabled, no update permission, both flags clear), counter 0, limit 0x0400, window 0, and the reset request is low.
- R2: Word address 0 is control, 1 is counter/command, 2 is the limit and 3 is the window. Control bit 7 is enable, bit 5 is update permission, bits 9:8 are a stored clock-select field, bit 11 is the unlocked flag and bit 10 is the reconfigured flag. All other bits read 0.
- R3: From reset until the first control write, writes to control, limit and window are accepted directly, and the unlock key pair has no effect.
- R4: After an accepted control write with bit 5 clear, writes to control, limit and window are ignored and the unlock key pair has no effect until reset.
- R5: With update permission set, writing 0xC520 and then 0xD928 to the counter register sets bit 11 and clears bit 10. Configuration writes are accepted only while bit 11 is set.
- R6: The unlocked period ends when an accepted control write occurs, which also sets bit 10. It also ends UNLOCK_CYC cycles after the second key word, whichever comes first. Configuration writes after that are ignored.
- R7: A key sequence completes only if its second word is the very next write. A write with any other data or to any other address cancels the sequence. A first key word always starts a new sequence.
- R8: Writing 0xA602 and then 0xB480 to the counter register clears the count.
- R9: While enabled and not tripped, the count rises by one each cycle. An accepted control write clears it. While disabled it holds its value.
- R10: When the count is greater than or equal to the limit while enabled, the reset request is high for exactly the next cycle. The count then freezes, and no further request occurs until reset.
- R11: With a nonzero window value, a completed feed while enabled and with the count below the window raises the reset request in the next cycle and trips the block as in R10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| word_addr | input | 2 | Register select |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for word_addr, combinational |
| rst_req | output | 1 | One-cycle reset request |

## Verification
A wrong key-sequence state first shows up as control bit 11 at the next read. It is either set after a broken pair or clear after a good one. It is also visible as a limit or window value that did or did not change on the following write. A wrong count or lock state shows up as a reset-request pulse that is early, late or missing, measured against the cycle predicted from the last feed or control write. A count that is not frozen after a trip shows up on the very next counter read.

// File: rtl/kp_wdog_pkg.sv
`timescale 1ns/1ps
package kp_wdog_pkg;
  localparam int DW = 16;

  typedef enum logic [1:0] {
    A_CS  = 2'd0,
    A_CNT = 2'd1,
    A_TO  = 2'd2,
    A_WIN = 2'd3
  } reg_sel_e;

  localparam logic [DW-1:0] KEY_UNL_A = 16'hC520;
  localparam logic [DW-1:0] KEY_UNL_B = 16'hD928;
  localparam logic [DW-1:0] KEY_REF_A = 16'hA602;
  localparam logic [DW-1:0] KEY_REF_B = 16'hB480;

  localparam int CS_UPD  = 5;
  localparam int CS_EN   = 7;
  localparam int CS_CLK  = 8;
  localparam int CS_RCFG = 10;
  localparam int CS_ULK  = 11;

  typedef enum logic [1:0] {KS_IDLE, KS_UNL, KS_REF} key_st_e;
endpackage

// File: rtl/kp_wdog_keyseq.sv
`timescale 1ns/1ps
module kp_wdog_keyseq
  import kp_wdog_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    word_addr,
  input  logic [DW-1:0] wdata,
  output logic          unlock_hit,
  output logic          refresh_hit
);
  key_st_e st_q, st_nx;

  always_comb begin
    st_nx       = st_q;
    unlock_hit  = 1'b0;
    refresh_hit = 1'b0;
    if (wr_en) begin
      st_nx = KS_IDLE;
      if (word_addr == A_CNT) begin
        if (st_q == KS_UNL && wdata == KEY_UNL_B)      unlock_hit  = 1'b1;
        else if (st_q == KS_REF && wdata == KEY_REF_B) refresh_hit = 1'b1;
        else if (wdata == KEY_UNL_A)                   st_nx = KS_UNL;
        else if (wdata == KEY_REF_A)                   st_nx = KS_REF;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= KS_IDLE;
    else if (wr_en) st_q <= st_nx;
  end

  // R7
  seq_done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (unlock_hit || refresh_hit) |=> st_q == KS_IDLE);
endmodule

// File: rtl/kp_wdog_cfg.sv
`timescale 1ns/1ps
module kp_wdog_cfg
  import kp_wdog_pkg::*;
#(
  parameter int               CNT_W      = 16,
  parameter int               UNLOCK_CYC = 128,
  parameter logic [CNT_W-1:0] TO_RST     = 16'h0400,
  parameter logic             EN_RST     = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       word_addr,
  input  logic [DW-1:0]    wdata,
  input  logic             unlock_hit,
  output logic             en,
  output logic             upd,
  output logic [1:0]       clk_sel,
  output logic [CNT_W-1:0] to_val,
  output logic [CNT_W-1:0] win_val,
  output logic             ulk,
  output logic             rcfg,
  output logic             cs_acc
);
  localparam int TW = $clog2(UNLOCK_CYC + 1);

  logic          fresh_q, fresh_nx;
  logic          ulk_q, ulk_nx, rcfg_q, rcfg_nx;
  logic [TW-1:0] tmr_q, tmr_nx;
  logic          wr_ok, to_wr, win_wr, unl_go;

  always_comb begin
    wr_ok  = fresh_q | ulk_q;
    cs_acc = wr_en && word_addr == A_CS  && wr_ok;
    to_wr  = wr_en && word_addr == A_TO  && wr_ok;
    win_wr = wr_en && word_addr == A_WIN && wr_ok;
    unl_go = unlock_hit && !fresh_q && upd;

    ulk_nx = ulk_q;
    tmr_nx = tmr_q;
    if (cs_acc) begin
      ulk_nx = 1'b0;
      tmr_nx = '0;
    end else if (unl_go) begin
      ulk_nx = 1'b1;
      tmr_nx = TW'(UNLOCK_CYC);
    end else if (ulk_q) begin
      if (tmr_q == TW'(1)) begin
        ulk_nx = 1'b0;
        tmr_nx = '0;
      end else begin
        tmr_nx = tmr_q - TW'(1);
      end
    end

    rcfg_nx  = unl_go ? 1'b0 : (cs_acc ? 1'b1 : rcfg_q);
    fresh_nx = fresh_q & ~cs_acc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fresh_q <= 1'b1;
      ulk_q   <= 1'b0;
      tmr_q   <= '0;
      rcfg_q  <= 1'b0;
    end else begin
      fresh_q <= fresh_nx;
      ulk_q   <= ulk_nx;
      tmr_q   <= tmr_nx;
      rcfg_q  <= rcfg_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en      <= EN_RST;
      upd     <= 1'b0;
      clk_sel <= 2'b00;
    end else if (cs_acc) begin
      en      <= wdata[CS_EN];
      upd     <= wdata[CS_UPD];
      clk_sel <= wdata[CS_CLK+1:CS_CLK];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     to_val <= TO_RST;
    else if (to_wr) to_val <= wdata[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      win_val <= '0;
    else if (win_wr) win_val <= wdata[CNT_W-1:0];
  end

  assign ulk  = ulk_q;
  assign rcfg = rcfg_q;

  // R3
  fresh_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fresh_q |-> !ulk_q);
  // R5
  unlock_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ulk_q) |-> $past(unlock_hit));
  // R4
  limit_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(to_val) |-> $past(fresh_q || ulk_q));
endmodule

// File: rtl/kp_wdog_counter.sv
`timescale 1ns/1ps
module kp_wdog_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] to_val,
  input  logic [CNT_W-1:0] win_val,
  input  logic             refresh_hit,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt,
  output logic             rst_req
);
  logic [CNT_W-1:0] cnt_q, cnt_nx;
  logic             trip_q, fire, viol;

  always_comb begin
    viol   = en && refresh_hit && (win_val != '0) && (cnt_q < win_val);
    fire   = !trip_q && ((en && cnt_q >= to_val) || viol);
    cnt_nx = cnt_q;
    if (!trip_q && !fire) begin
      if (clr || refresh_hit) cnt_nx = '0;
      else if (en)            cnt_nx = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      trip_q  <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      cnt_q   <= cnt_nx;
      trip_q  <= trip_q | fire;
      rst_req <= fire;
    end
  end

  assign cnt = cnt_q;

  // R10
  req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
  // R10
  trip_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trip_q |=> (trip_q && $stable(cnt_q)));
endmodule

// File: rtl/kp_wdog.sv
`timescale 1ns/1ps
module kp_wdog
  import kp_wdog_pkg::*;
#(
  parameter int               CNT_W      = 16,
  parameter int               UNLOCK_CYC = 128,
  parameter logic [CNT_W-1:0] TO_RST     = 16'h0400,
  parameter logic             EN_RST     = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    word_addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          rst_req
);
  logic             unlock_hit, refresh_hit;
  logic             en, upd, ulk, rcfg, cs_acc;
  logic [1:0]       clk_sel;
  logic [CNT_W-1:0] to_val, win_val, cnt;

  kp_wdog_keyseq u_keys (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .word_addr(word_addr),
    .wdata(wdata), .unlock_hit(unlock_hit), .refresh_hit(refresh_hit)
  );

  kp_wdog_cfg #(
    .CNT_W(CNT_W), .UNLOCK_CYC(UNLOCK_CYC), .TO_RST(TO_RST), .EN_RST(EN_RST)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .word_addr(word_addr),
    .wdata(wdata), .unlock_hit(unlock_hit), .en(en), .upd(upd),
    .clk_sel(clk_sel), .to_val(to_val), .win_val(win_val), .ulk(ulk),
    .rcfg(rcfg), .cs_acc(cs_acc)
  );

  kp_wdog_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(en), .to_val(to_val), .win_val(win_val),
    .refresh_hit(refresh_hit), .clr(cs_acc), .cnt(cnt), .rst_req(rst_req)
  );

  always_comb begin
    case (word_addr)
      A_CS:    rdata = {4'b0, ulk, rcfg, clk_sel, en, 1'b0, upd, 5'b0};
      A_CNT:   rdata = DW'(cnt);
      A_TO:    rdata = DW'(to_val);
      default: rdata = DW'(win_val);
    endcase
  end
endmodule

// File: tb/kp_wdog_tb.sv
`timescale 1ns/1ps
module kp_wdog_tb;
  logic        clk, rst_n, wr_en, rst_req;
  logic [1:0]  word_addr;
  logic [15:0] wdata, rdata;
  int n_cmp = 0, n_bad = 0;

  kp_wdog u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .word_addr(word_addr),
    .wdata(wdata), .rdata(rdata), .rst_req(rst_req)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [15:0] cs_exp(logic ul, logic rc, logic [1:0] cs,
                                         logic e, logic u);
    return {4'b0, ul, rc, cs, e, 1'b0, u, 5'b0};
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    wr_en = 1'b1; word_addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rdchk(string tag, logic [1:0] a, logic [15:0] exp);
    word_addr = a;
    #1;
    chk(tag, rdata, exp);
  endtask

  task automatic run(int n, output int pulses, output int at);
    pulses = 0; at = 0;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (rst_req) begin
        pulses++;
        if (at == 0) at = i;
      end
    end
  endtask

  task automatic do_reset;
    rst_n = 1'b0; wr_en = 1'b0; word_addr = 2'd0; wdata = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic unlock;
    wr(2'd1, 16'hC520);
    wr(2'd1, 16'hD928);
  endtask

  task automatic feed;
    wr(2'd1, 16'hA602);
    wr(2'd1, 16'hB480);
  endtask

  initial begin
    #1200000;
    n_bad++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int p, at, tot;
    logic [1:0] pend;
    logic ul, rc;
    void'($urandom(32'd2024));

    // R1 reset state
    do_reset;
    rdchk("R1 count", 2'd1, 16'h0000);
    rdchk("R1 control", 2'd0, 16'h0080);
    rdchk("R1 limit", 2'd2, 16'h0400);
    rdchk("R1 window", 2'd3, 16'h0000);
    chk("R1 rst_req", {15'b0, rst_req}, 16'h0);

    // R3 fresh: keys do nothing, writes taken directly
    unlock;
    rdchk("R3 keys ignored", 2'd0, 16'h0080);
    wr(2'd2, 16'h0055);
    rdchk("R3 limit written", 2'd2, 16'h0055);
    wr(2'd2, 16'd20);
    wr(2'd0, 16'h00A0);
    rdchk("R2 control layout", 2'd0, cs_exp(0, 1, 2'd0, 1, 1));
    run(30, p, at);
    chk("R10 pulse count", 16'(p), 16'd1);
    chk("R10 pulse cycle", 16'(at), 16'd21);
    rdchk("R10 count frozen", 2'd1, 16'd20);
    run(40, p, at);
    chk("R10 no second pulse", 16'(p), 16'd0);

    // R4 no update permission: frozen
    do_reset;
    wr(2'd0, 16'h0080);
    wr(2'd2, 16'h0010);
    rdchk("R4 limit kept", 2'd2, 16'h0400);
    unlock;
    rdchk("R4 keys ignored", 2'd0, cs_exp(0, 1, 2'd0, 1, 0));
    wr(2'd3, 16'h0007);
    rdchk("R4 window kept", 2'd3, 16'h0000);

    // R5 / R6 / R8 / R9 with permission
    do_reset;
    wr(2'd0, 16'h0120);
    rdchk("R2 clock field", 2'd0, 16'h0520);
    wr(2'd2, 16'h0030);
    rdchk("R5 locked write", 2'd2, 16'h0400);
    unlock;
    rdchk("R5 unlocked flag", 2'd0, 16'h0920);
    wr(2'd2, 16'h0030);
    rdchk("R5 unlocked write", 2'd2, 16'h0030);
    wr(2'd0, 16'h01A0);
    rdchk("R6 closed by control", 2'd0, cs_exp(0, 1, 2'd1, 1, 1));
    run(10, p, at);
    rdchk("R9 counting", 2'd1, 16'd10);
    feed;
    rdchk("R8 feed clears", 2'd1, 16'd0);
    tot = 0;
    for (int k = 0; k < 5; k++) begin
      run(20, p, at);
      tot += p;
      feed;
    end
    chk("R8 fed no request", 16'(tot), 16'd0);
    run(60, p, at);
    chk("R10 starve pulses", 16'(p), 16'd1);
    chk("R10 starve cycle", 16'(at), 16'd49);

    // R11 window
    do_reset;
    wr(2'd3, 16'd10);
    wr(2'd2, 16'd100);
    wr(2'd0, 16'h00A0);
    feed;
    chk("R11 early feed", {15'b0, rst_req}, 16'h1);
    rdchk("R11 frozen", 2'd1, 16'd1);
    do_reset;
    wr(2'd3, 16'd10);
    wr(2'd2, 16'd100);
    wr(2'd0, 16'h00A0);
    run(15, p, at);
    feed;
    chk("R11 late feed ok", {15'b0, rst_req}, 16'h0);
    rdchk("R11 late feed clears", 2'd1, 16'd0);

    // R6 expiry
    do_reset;
    wr(2'd0, 16'h0120);
    unlock;
    run(127, p, at);
    rdchk("R6 still open", 2'd0, 16'h0920);
    run(1, p, at);
    rdchk("R6 expired", 2'd0, 16'h0120);
    wr(2'd2, 16'h0077);
    rdchk("R6 write after expiry", 2'd2, 16'h0400);

    // R7 cancel cases
    wr(2'd1, 16'hC520); wr(2'd1, 16'h1234); wr(2'd1, 16'hD928);
    rdchk("R7 wrong word", 2'd0, 16'h0120);
    wr(2'd1, 16'hC520); wr(2'd3, 16'h0005); wr(2'd1, 16'hD928);
    rdchk("R7 other address", 2'd0, 16'h0120);
    rdchk("R7 window kept", 2'd3, 16'h0000);
    wr(2'd1, 16'hC520); wr(2'd1, 16'hC520); wr(2'd1, 16'hD928);
    rdchk("R7 restart", 2'd0, 16'h0920);
    wr(2'd0, 16'h0120);
    rdchk("R6 relock", 2'd0, 16'h0520);

    // R9 disabled holds
    run(50, p, at);
    chk("R9 disabled no request", 16'(p), 16'd0);
    rdchk("R9 disabled holds", 2'd1, 16'd0);

    // R7 random key traffic against a model
    pend = 2'd0; ul = 1'b0; rc = 1'b1;
    for (int it = 0; it < 80; it++) begin
      logic [1:0]  a;
      logic [15:0] d;
      logic        hit_u, hit_r;
      a = 2'd1;
      case ($urandom_range(0, 5))
        0: d = 16'hC520;
        1: d = 16'hD928;
        2: d = 16'hA602;
        3: d = 16'hB480;
        4: d = 16'($urandom);
        default: begin a = 2'd0; d = 16'h0120; end
      endcase
      hit_u = (a == 2'd1) && pend == 2'd1 && d == 16'hD928;
      hit_r = (a == 2'd1) && pend == 2'd2 && d == 16'hB480;
      if (a != 2'd1 || hit_u || hit_r) pend = 2'd0;
      else if (d == 16'hC520)          pend = 2'd1;
      else if (d == 16'hA602)          pend = 2'd2;
      else                             pend = 2'd0;
      if (a == 2'd0 && ul) begin ul = 1'b0; rc = 1'b1; end
      else if (hit_u)      begin ul = 1'b1; rc = 1'b0; end
      wr(a, d);
      rdchk("R7 random sequence", 2'd0, cs_exp(ul, rc, 2'd1, 0, 1));
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule